// File: doc/BRIEF.md
# Host Register Queue Port

This block sits between a processor's register bus and the five queues of a serial bus controller. Two queues carry traffic out to the bus engine: command words and outbound data words. Three carry traffic back from it: transfer results, inbound data words and in-band interrupt events. The processor pushes by writing a push register, pops by reading a pop register, and reads free-space counts, fill levels and an empty-status word from separate read-only registers.

The queues are small synchronous FIFOs inside the block, all of one parameterised depth. The bus engine is not part of the block. It appears only as the FIFO-facing ports. It pops command and outbound data words, it pushes results, inbound data and interrupt events, and it receives threshold flags for its interrupt logic. A read access is marked by a single-cycle `bus_rd` strobe. Read data is registered and appears on `bus_rdata` in the cycle after the strobe. A pop happens on that strobe only, so each completed read removes exactly one entry.

Word register offsets on `bus_addr`:

| Offset | Register |
|---|---|
| 0x0 | command push |
| 0x1 | outbound-data push |
| 0x2 | result pop |
| 0x3 | inbound-data pop |
| 0x4 | interrupt-event pop |
| 0x5 | command room |
| 0x6 | outbound-data room |
| 0x7 | result level |
| 0x8 | inbound-data level |
| 0x9 | interrupt-event level |
| 0xA | empty-status word |

Top module: `hrq_port`

## Requirements
- R1: After reset every queue is empty. Both room registers read DEPTH (default 8), all three level registers read 0, and the empty-status word reads 0x7.
- R2: A bus write to offset 0x0 or 0x1 appends `bus_wdata` to the command or outbound-data queue, provided that queue is not full. The engine sees the entries in write order on `cmd_word`/`sdo_data`, qualified by `cmd_valid`/`sdo_valid`, and removes the head with `cmd_pop`/`sdo_pop`.
- R3: A bus write to a push register while its queue holds DEPTH entries is discarded. The room stays 0 and the stored entries and their order are unchanged.
- R4: A read of offset 0x0 or 0x1, or of any offset above 0xA, returns 0.
- R5: A read of offset 0x2, 0x3 or 0x4 returns the head of the result, inbound-data or interrupt-event queue in the next cycle and removes exactly that one entry.
- R6: A read of a pop register while its queue is empty removes nothing, and its data is undefined. A bus write to a pop register leaves the queue unchanged.
- R7: Offsets 0x5 and 0x6 return DEPTH minus the level of the command and outbound-data queues. Offsets 0x7, 0x8 and 0x9 return the levels of the result, inbound-data and interrupt-event queues.
- R8: The empty-status word has bit 0 = result queue empty, bit 1 = interrupt-event queue empty and bit 2 = inbound-data queue empty. All other bits are 0.
- R9: The command head is decoded as follows: `cmd_rnw` is bit 0, `cmd_target` is bits 7:1, `cmd_len` is bits 19:8, `cmd_rstart` is bit 20, `cmd_bcast` is bit 21 and `cmd_ccc` is bit 22.
- R10: An interrupt event pushed with `ibi_push` is stored as address in bits 23:17, data byte in bits 15:8 and sync number in bits 7:0. Bits 31:24 and bit 16 are 0.
- R11: `cmd_almost_empty`/`sdo_almost_empty` are 1 when the level is at most LOW_MARK (default 1). `rsp_almost_full`/`sdi_almost_full`/`ibi_almost_full` are 1 when the level is at least HIGH_MARK (default 6).
- R12: `rsp_full`/`sdi_full`/`ibi_full` are 1 when the queue holds DEPTH entries. An engine push while full is dropped, and an engine pop of an empty command or outbound-data queue has no effect.
- R13: A push and a pop on the same non-empty, non-full queue in one cycle leave its level unchanged and keep FIFO order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | 4 | word register offset |
| bus_wr | input | 1 | write strobe |
| bus_wdata | input | 32 | write data |
| bus_rd | input | 1 | completed-read strobe |
| bus_rdata | output | 32 | registered read data, valid the cycle after `bus_rd` |
| cmd_valid | output | 1 | command queue not empty |
| cmd_pop | input | 1 | engine removes command head |
| cmd_word | output | 32 | raw command head |
| cmd_rnw | output | 1 | head: read-not-write |
| cmd_target | output | 7 | head: target address |
| cmd_len | output | 12 | head: payload length |
| cmd_rstart | output | 1 | head: repeated-start flag |
| cmd_bcast | output | 1 | head: broadcast-header flag |
| cmd_ccc | output | 1 | head: common-command flag |
| sdo_valid | output | 1 | outbound-data queue not empty |
| sdo_pop | input | 1 | engine removes outbound-data head |
| sdo_data | output | 32 | outbound-data head |
| rsp_push | input | 1 | engine pushes a result |
| rsp_data | input | 32 | result word |
| rsp_full | output | 1 | result queue full |
| sdi_push | input | 1 | engine pushes inbound data |
| sdi_data | input | 32 | inbound data word |
| sdi_full | output | 1 | inbound-data queue full |
| ibi_push | input | 1 | engine pushes an interrupt event |
| ibi_addr | input | 7 | event dynamic address |
| ibi_mdb | input | 8 | event data byte |
| ibi_sync | input | 8 | event sync number |
| ibi_full | output | 1 | interrupt-event queue full |
| cmd_almost_empty | output | 1 | command level at or below low mark |
| sdo_almost_empty | output | 1 | outbound-data level at or below low mark |
| rsp_almost_full | output | 1 | result level at or above high mark |
| sdi_almost_full | output | 1 | inbound-data level at or above high mark |
| ibi_almost_full | output | 1 | interrupt-event level at or above high mark |

## Verification
The bench targets these corner cases:

- Overfilling the command queue by one word. A design that accepted the extra word would wrap its write pointer and overwrite the oldest command, so the drained order would come out wrong.
- Reading empty pop registers, and writing to pop registers. A design that popped without checking for empty would drive its level negative and report a huge count.
- Pushing and popping one queue in the same cycle. A design that let the pop win would lose the entry, and one that let the push win would gain an extra entry.
- Long random mixes of bus reads, bus writes and engine traffic, compared against a queue model every cycle. These expose swapped status bits, off-by-one room values, threshold flags compared with the wrong operator, and interrupt-event fields packed at the wrong bit positions.

// File: rtl/hrq_pkg.sv
package hrq_pkg;

  localparam int NQ = 5;
  localparam int Q_CMD = 0;
  localparam int Q_SDO = 1;
  localparam int Q_RSP = 2;
  localparam int Q_SDI = 3;
  localparam int Q_IBI = 4;

  localparam logic [3:0] OFS_CMD_PUSH  = 4'h0;
  localparam logic [3:0] OFS_SDO_PUSH  = 4'h1;
  localparam logic [3:0] OFS_RSP_POP   = 4'h2;
  localparam logic [3:0] OFS_SDI_POP   = 4'h3;
  localparam logic [3:0] OFS_IBI_POP   = 4'h4;
  localparam logic [3:0] OFS_CMD_ROOM  = 4'h5;
  localparam logic [3:0] OFS_SDO_ROOM  = 4'h6;
  localparam logic [3:0] OFS_RSP_LVL   = 4'h7;
  localparam logic [3:0] OFS_SDI_LVL   = 4'h8;
  localparam logic [3:0] OFS_IBI_LVL   = 4'h9;
  localparam logic [3:0] OFS_EMPTY     = 4'hA;

  typedef struct packed {
    logic [8:0]  spare;
    logic        ccc;
    logic        bcast;
    logic        rstart;
    logic [11:0] len;
    logic [6:0]  target;
    logic        rnw;
  } cmd_fields_t;

  // Free space as a 32-bit register value.
  function automatic logic [31:0] room_word(input int depth, input int lvl);
    return 32'(depth - lvl);
  endfunction

  // Interrupt-event entry layout.
  function automatic logic [31:0] pack_event(input logic [6:0] a,
                                             input logic [7:0] m,
                                             input logic [7:0] s);
    return {8'h00, a, 1'b0, m, s};
  endfunction

  // Empty-status word: result, event, inbound-data in bits 0,1,2.
  function automatic logic [31:0] empty_word(input logic rsp_e,
                                             input logic ibi_e,
                                             input logic sdi_e);
    return {29'd0, sdi_e, ibi_e, rsp_e};
  endfunction

endpackage

// File: rtl/hrq_fifo.sv
module hrq_fifo #(
  parameter int AW       = 3,
  parameter int W        = 32,
  parameter int OUTBOUND = 1,
  parameter int LOW_MARK = 1,
  parameter int HIGH_MARK = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [AW:0]   level,
  output logic          empty,
  output logic          near
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  generate
    if (OUTBOUND != 0) begin : g_low
      assign near = (level <= LW'(LOW_MARK));
    end else begin : g_high
      assign near = (level >= LW'(HIGH_MARK));
    end
  endgenerate

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> level == $past(level));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> level == '0);

  p_both_steady_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> level == $past(level));

endmodule

// File: rtl/hrq_decode.sv
module hrq_decode
  import hrq_pkg::*;
(
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic       wr_cmd,
  output logic       wr_sdo,
  output logic       rd_rsp,
  output logic       rd_sdi,
  output logic       rd_ibi
);
  always_comb begin
    wr_cmd = bus_wr && (bus_addr == OFS_CMD_PUSH);
    wr_sdo = bus_wr && (bus_addr == OFS_SDO_PUSH);
    rd_rsp = bus_rd && (bus_addr == OFS_RSP_POP);
    rd_sdi = bus_rd && (bus_addr == OFS_SDI_POP);
    rd_ibi = bus_rd && (bus_addr == OFS_IBI_POP);
  end
endmodule

// File: rtl/hrq_port.sv
module hrq_port
  import hrq_pkg::*;
#(
  parameter int Q_AW      = 3,
  parameter int LOW_MARK  = 1,
  parameter int HIGH_MARK = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        cmd_valid,
  input  logic        cmd_pop,
  output logic [31:0] cmd_word,
  output logic        cmd_rnw,
  output logic [6:0]  cmd_target,
  output logic [11:0] cmd_len,
  output logic        cmd_rstart,
  output logic        cmd_bcast,
  output logic        cmd_ccc,
  output logic        sdo_valid,
  input  logic        sdo_pop,
  output logic [31:0] sdo_data,
  input  logic        rsp_push,
  input  logic [31:0] rsp_data,
  output logic        rsp_full,
  input  logic        sdi_push,
  input  logic [31:0] sdi_data,
  output logic        sdi_full,
  input  logic        ibi_push,
  input  logic [6:0]  ibi_addr,
  input  logic [7:0]  ibi_mdb,
  input  logic [7:0]  ibi_sync,
  output logic        ibi_full,
  output logic        cmd_almost_empty,
  output logic        sdo_almost_empty,
  output logic        rsp_almost_full,
  output logic        sdi_almost_full,
  output logic        ibi_almost_full
);
  localparam int DEPTH = 1 << Q_AW;
  localparam int LW    = Q_AW + 1;

  logic          q_push [NQ];
  logic          q_pop  [NQ];
  logic [31:0]   q_din  [NQ];
  logic [31:0]   q_dout [NQ];
  logic [LW-1:0] q_lvl  [NQ];
  logic          q_empty[NQ];
  logic          q_near [NQ];

  logic wr_cmd, wr_sdo, rd_rsp, rd_sdi, rd_ibi;
  cmd_fields_t head;

  hrq_decode u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .wr_cmd   (wr_cmd),
    .wr_sdo   (wr_sdo),
    .rd_rsp   (rd_rsp),
    .rd_sdi   (rd_sdi),
    .rd_ibi   (rd_ibi)
  );

  always_comb begin
    q_push[Q_CMD] = wr_cmd;    q_pop[Q_CMD] = cmd_pop;  q_din[Q_CMD] = bus_wdata;
    q_push[Q_SDO] = wr_sdo;    q_pop[Q_SDO] = sdo_pop;  q_din[Q_SDO] = bus_wdata;
    q_push[Q_RSP] = rsp_push;  q_pop[Q_RSP] = rd_rsp;   q_din[Q_RSP] = rsp_data;
    q_push[Q_SDI] = sdi_push;  q_pop[Q_SDI] = rd_sdi;   q_din[Q_SDI] = sdi_data;
    q_push[Q_IBI] = ibi_push;  q_pop[Q_IBI] = rd_ibi;
    q_din[Q_IBI]  = pack_event(ibi_addr, ibi_mdb, ibi_sync);
  end

  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    hrq_fifo #(
      .AW        (Q_AW),
      .W         (32),
      .OUTBOUND  ((gi < 2) ? 1 : 0),
      .LOW_MARK  (LOW_MARK),
      .HIGH_MARK (HIGH_MARK)
    ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[gi]),
      .din   (q_din[gi]),
      .pop   (q_pop[gi]),
      .dout  (q_dout[gi]),
      .level (q_lvl[gi]),
      .empty (q_empty[gi]),
      .near  (q_near[gi])
    );
  end

  // Engine-facing side
  assign head       = cmd_fields_t'(q_dout[Q_CMD]);
  assign cmd_word   = q_dout[Q_CMD];
  assign cmd_valid  = !q_empty[Q_CMD];
  assign cmd_rnw    = head.rnw;
  assign cmd_target = head.target;
  assign cmd_len    = head.len;
  assign cmd_rstart = head.rstart;
  assign cmd_bcast  = head.bcast;
  assign cmd_ccc    = head.ccc;
  assign sdo_valid  = !q_empty[Q_SDO];
  assign sdo_data   = q_dout[Q_SDO];
  assign rsp_full   = (q_lvl[Q_RSP] == LW'(DEPTH));
  assign sdi_full   = (q_lvl[Q_SDI] == LW'(DEPTH));
  assign ibi_full   = (q_lvl[Q_IBI] == LW'(DEPTH));
  assign cmd_almost_empty = q_near[Q_CMD];
  assign sdo_almost_empty = q_near[Q_SDO];
  assign rsp_almost_full  = q_near[Q_RSP];
  assign sdi_almost_full  = q_near[Q_SDI];
  assign ibi_almost_full  = q_near[Q_IBI];

  // Registered read path
  logic [31:0] rd_next;
  always_comb begin
    case (bus_addr)
      OFS_RSP_POP:  rd_next = q_dout[Q_RSP];
      OFS_SDI_POP:  rd_next = q_dout[Q_SDI];
      OFS_IBI_POP:  rd_next = q_dout[Q_IBI];
      OFS_CMD_ROOM: rd_next = room_word(DEPTH, int'(q_lvl[Q_CMD]));
      OFS_SDO_ROOM: rd_next = room_word(DEPTH, int'(q_lvl[Q_SDO]));
      OFS_RSP_LVL:  rd_next = 32'(q_lvl[Q_RSP]);
      OFS_SDI_LVL:  rd_next = 32'(q_lvl[Q_SDI]);
      OFS_IBI_LVL:  rd_next = 32'(q_lvl[Q_IBI]);
      OFS_EMPTY:    rd_next = empty_word(q_empty[Q_RSP], q_empty[Q_IBI], q_empty[Q_SDI]);
      default:      rd_next = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 32'd0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  p_pop_needs_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_lvl[Q_RSP] < $past(q_lvl[Q_RSP])) |-> $past(bus_rd && bus_addr == OFS_RSP_POP));

  p_push_reg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && (bus_addr == OFS_CMD_PUSH || bus_addr == OFS_SDO_PUSH))
      |-> bus_rdata == 32'd0);

endmodule

// File: tb/sim_hrq_port.sv
`timescale 1ns/1ps
module sim_hrq_port;
  localparam int D  = 8;
  localparam int LO = 1;
  localparam int HI = 6;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0; logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cmd_valid, cmd_pop = 0, cmd_rnw, cmd_rstart, cmd_bcast, cmd_ccc;
  logic [31:0] cmd_word; logic [6:0] cmd_target; logic [11:0] cmd_len;
  logic sdo_valid, sdo_pop = 0; logic [31:0] sdo_data;
  logic rsp_push = 0, rsp_full, sdi_push = 0, sdi_full, ibi_push = 0, ibi_full;
  logic [31:0] rsp_data = 0, sdi_data = 0;
  logic [6:0] ibi_addr = 0; logic [7:0] ibi_mdb = 0, ibi_sync = 0;
  logic cmd_ae, sdo_ae, rsp_af, sdi_af, ibi_af;

  always #10 clk = ~clk;

  hrq_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_pop(cmd_pop), .cmd_word(cmd_word),
    .cmd_rnw(cmd_rnw), .cmd_target(cmd_target), .cmd_len(cmd_len),
    .cmd_rstart(cmd_rstart), .cmd_bcast(cmd_bcast), .cmd_ccc(cmd_ccc),
    .sdo_valid(sdo_valid), .sdo_pop(sdo_pop), .sdo_data(sdo_data),
    .rsp_push(rsp_push), .rsp_data(rsp_data), .rsp_full(rsp_full),
    .sdi_push(sdi_push), .sdi_data(sdi_data), .sdi_full(sdi_full),
    .ibi_push(ibi_push), .ibi_addr(ibi_addr), .ibi_mdb(ibi_mdb),
    .ibi_sync(ibi_sync), .ibi_full(ibi_full),
    .cmd_almost_empty(cmd_ae), .sdo_almost_empty(sdo_ae),
    .rsp_almost_full(rsp_af), .sdi_almost_full(sdi_af), .ibi_almost_full(ibi_af)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mq_cmd[$], mq_sdo[$], mq_rsp[$], mq_sdi[$], mq_ibi[$];
  logic [31:0] exp_rd; logic exp_ok; string exp_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lvl(input int n); return 32'(n); endfunction

  task automatic model_edge(input logic [3:0] a, input logic wr, input logic rd,
                            input logic [31:0] wd);
    logic [31:0] ev;
    bit p_cmd, p_sdo, p_rsp, p_sdi, p_ibi, g_cmd, g_sdo, g_rsp, g_sdi, g_ibi;
    ev = {8'h00, ibi_addr, 1'b0, ibi_mdb, ibi_sync};
    exp_ok = 0;
    if (rd) begin
      exp_ok = 1;
      case (a)
        4'h2: begin exp_tag = "R5"; exp_ok = mq_rsp.size() > 0; if (exp_ok) exp_rd = mq_rsp[0]; end
        4'h3: begin exp_tag = "R5"; exp_ok = mq_sdi.size() > 0; if (exp_ok) exp_rd = mq_sdi[0]; end
        4'h4: begin exp_tag = "R5"; exp_ok = mq_ibi.size() > 0; if (exp_ok) exp_rd = mq_ibi[0]; end
        4'h5: begin exp_tag = "R7"; exp_rd = lvl(D - mq_cmd.size()); end
        4'h6: begin exp_tag = "R7"; exp_rd = lvl(D - mq_sdo.size()); end
        4'h7: begin exp_tag = "R7"; exp_rd = lvl(mq_rsp.size()); end
        4'h8: begin exp_tag = "R7"; exp_rd = lvl(mq_sdi.size()); end
        4'h9: begin exp_tag = "R7"; exp_rd = lvl(mq_ibi.size()); end
        4'hA: begin exp_tag = "R8";
          exp_rd = {29'd0, mq_sdi.size() == 0, mq_ibi.size() == 0, mq_rsp.size() == 0}; end
        default: begin exp_tag = "R4"; exp_rd = 0; end
      endcase
    end
    p_cmd = wr && a == 4'h0 && mq_cmd.size() < D;
    p_sdo = wr && a == 4'h1 && mq_sdo.size() < D;
    p_rsp = rsp_push && mq_rsp.size() < D;
    p_sdi = sdi_push && mq_sdi.size() < D;
    p_ibi = ibi_push && mq_ibi.size() < D;
    g_cmd = cmd_pop && mq_cmd.size() > 0;
    g_sdo = sdo_pop && mq_sdo.size() > 0;
    g_rsp = rd && a == 4'h2 && mq_rsp.size() > 0;
    g_sdi = rd && a == 4'h3 && mq_sdi.size() > 0;
    g_ibi = rd && a == 4'h4 && mq_ibi.size() > 0;
    if (g_cmd) void'(mq_cmd.pop_front());
    if (g_sdo) void'(mq_sdo.pop_front());
    if (g_rsp) void'(mq_rsp.pop_front());
    if (g_sdi) void'(mq_sdi.pop_front());
    if (g_ibi) void'(mq_ibi.pop_front());
    if (p_cmd) mq_cmd.push_back(wd);
    if (p_sdo) mq_sdo.push_back(wd);
    if (p_rsp) mq_rsp.push_back(rsp_data);
    if (p_sdi) mq_sdi.push_back(sdi_data);
    if (p_ibi) mq_ibi.push_back(ev);
  endtask

  task automatic compare_all();
    chk("R2 cmd_valid", 32'(cmd_valid), 32'(mq_cmd.size() > 0));
    if (mq_cmd.size() > 0) begin
      chk("R2 cmd_word", cmd_word, mq_cmd[0]);
      chk("R9 cmd fields",
          {9'd0, cmd_ccc, cmd_bcast, cmd_rstart, cmd_len, cmd_target, cmd_rnw},
          {9'd0, mq_cmd[0][22], mq_cmd[0][21], mq_cmd[0][20], mq_cmd[0][19:8],
           mq_cmd[0][7:1], mq_cmd[0][0]});
    end
    chk("R2 sdo_valid", 32'(sdo_valid), 32'(mq_sdo.size() > 0));
    if (mq_sdo.size() > 0) chk("R2 sdo_data", sdo_data, mq_sdo[0]);
    chk("R12 full flags", {29'd0, rsp_full, sdi_full, ibi_full},
        {29'd0, mq_rsp.size() == D, mq_sdi.size() == D, mq_ibi.size() == D});
    chk("R11 marks", {27'd0, cmd_ae, sdo_ae, rsp_af, sdi_af, ibi_af},
        {27'd0, mq_cmd.size() <= LO, mq_sdo.size() <= LO, mq_rsp.size() >= HI,
         mq_sdi.size() >= HI, mq_ibi.size() >= HI});
    if (exp_ok) chk({exp_tag, " bus_rdata"}, bus_rdata, exp_rd);
  endtask

  task automatic step(input logic [3:0] a, input logic wr, input logic rd,
                      input logic [31:0] wd);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    @(posedge clk);
    model_edge(a, wr, rd, wd);
    @(negedge clk);
    compare_all();
    bus_wr = 0; bus_rd = 0;
    cmd_pop = 0; sdo_pop = 0; rsp_push = 0; sdi_push = 0; ibi_push = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
    step(a, 0, 1, 0);
    v = bus_rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    rd_reg(4'hA, v); chk("R1 empty word", v, 32'h7);
    rd_reg(4'h5, v); chk("R1 cmd room", v, D);
    rd_reg(4'h6, v); chk("R1 sdo room", v, D);
    rd_reg(4'h9, v); chk("R1 ibi level", v, 0);

    // R2/R9 commands with distinct field patterns
    step(4'h0, 1, 0, 32'h0055_A5A5);
    step(4'h0, 1, 0, 32'h0020_0F01);
    step(4'h1, 1, 0, 32'hDEAD_BEEF);
    rd_reg(4'h0, v); chk("R4 push reg read", v, 0);
    cmd_pop = 1; step(4'h0, 0, 0, 0);
    cmd_pop = 1; step(4'h0, 0, 0, 0);
    cmd_pop = 1; step(4'h0, 0, 0, 0);   // pop of empty: R12

    // R3 overfill command queue
    for (int i = 0; i < D + 1; i++) step(4'h0, 1, 0, 32'h100 + i);
    rd_reg(4'h5, v); chk("R3 room after overfill", v, 0);
    for (int i = 0; i < D; i++) begin
      chk("R3 drain order", cmd_word, 32'h100 + i);
      cmd_pop = 1; step(4'h0, 0, 0, 0);
    end

    // R6 reads of empty pop registers, writes to pop registers
    step(4'h2, 0, 1, 0);
    rd_reg(4'h7, v); chk("R6 rsp level after empty read", v, 0);
    rsp_push = 1; rsp_data = 32'hCAFE_0001; step(4'h0, 0, 0, 0);
    step(4'h2, 1, 0, 32'h1234_5678);
    rd_reg(4'h7, v); chk("R6 rsp level after write to pop", v, 1);
    rd_reg(4'h2, v); chk("R5 rsp pop value", v, 32'hCAFE_0001);

    // R10 event packing
    ibi_push = 1; ibi_addr = 7'h5A; ibi_mdb = 8'hC3; ibi_sync = 8'h17;
    step(4'h0, 0, 0, 0);
    rd_reg(4'h4, v); chk("R10 event word", v, 32'h00B4_C317);

    // R11/R12 fill inbound data queue past full
    for (int i = 0; i < D + 2; i++) begin
      sdi_push = 1; sdi_data = 32'h5D0 + i; step(4'h0, 0, 0, 0);
    end
    chk("R12 sdi full", 32'(sdi_full), 1);
    chk("R11 sdi high mark", 32'(sdi_af), 1);
    for (int i = 0; i < D; i++) begin
      rd_reg(4'h3, v); chk("R12 sdi order", v, 32'h5D0 + i);
    end

    // R13 simultaneous push and pop
    for (int i = 0; i < 3; i++) step(4'h0, 1, 0, 32'h700 + i);
    cmd_pop = 1; step(4'h0, 1, 0, 32'h7FF);
    rd_reg(4'h5, v); chk("R13 cmd room steady", v, D - 3);
    chk("R13 new head", cmd_word, 32'h701);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      cmd_pop  = ($urandom_range(0, 3) == 0);
      sdo_pop  = ($urandom_range(0, 3) == 0);
      rsp_push = ($urandom_range(0, 2) == 0); rsp_data = $urandom;
      sdi_push = ($urandom_range(0, 2) == 0); sdi_data = $urandom;
      ibi_push = ($urandom_range(0, 3) == 0);
      ibi_addr = 7'($urandom); ibi_mdb = 8'($urandom); ibi_sync = 8'($urandom);
      step(4'($urandom_range(0, 12)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom);
    end
    summary();
  end
endmodule